// File: doc/BRIEF.md
# Filament Bridge PWM Generator

This block produces the two drive waveforms for an external full bridge that powers a display filament. The first phase output drives one side of the bridge during the first half of each switching period. The second phase output drives the other side during the second half. Over one period the total on-time is a programmed number of units out of 200. Each unit of time is one pulse of the multiplex scan tick, so the filament switching frequency stays locked to the display scan and cannot beat against it.

The programmed duty value is sampled only when a new period begins, so a write in mid-period never distorts the running waveform. Values that would consume the off-time needed between phase reversals are clamped. Each half-period therefore always ends with at least one unit in which both outputs are low. When filament drive is disabled, the two outputs simply mirror two general-purpose output bits.

Top module: `fil_bridge_pwm`

## Requirements
- R1: While the reset input is low, both phase outputs are low regardless of the other inputs.
- R2: With drive enabled, the position in the period advances by one unit on each clock edge where `scan_tick` is high. It wraps from unit 199 to unit 0. At unit k below 100, `phase_a` is high exactly when k < ceil(D/2), where D is the effective duty; `phase_b` is low.
- R3: At unit k of 100 or above, `phase_b` is high exactly when k-100 < floor(D/2), and `phase_a` is low.
- R4: The number of units in one period during which either output is high equals the effective duty D.
- R5: A duty input above 198 is treated as 198. Each phase is then on for 99 units.
- R6: The two outputs are never high together while driving. Units 99 and 199 are always both-low dead units, so every phase reversal is separated by at least one scan unit.
- R7: A change of the duty input takes effect only at the start of the next period, meaning after the tick that wraps unit 199 to unit 0.
- R8: Without a `scan_tick`, the position and the outputs hold their values.
- R9: With drive disabled, `phase_a` follows `gpo[0]` and `phase_b` follows `gpo[1]`, one clock later.
- R10: An effective duty of 0 keeps both outputs low for the whole period.
- R11: Enabling drive starts a period at unit 0 using the duty input present at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_tick | input | 1 | One-cycle pulse per multiplex scan unit |
| fil_en | input | 1 | 1 = bridge PWM drive, 0 = general-purpose outputs |
| duty | input | 8 | On-time per period in units of 1/200 |
| gpo | input | 2 | General-purpose levels for the two outputs when disabled |
| phase_a | output | 1 | First bridge phase (first half-period) |
| phase_b | output | 1 | Second bridge phase (second half-period) |

## Verification
The hardest condition to reach from the ports is a duty write that arrives in the middle of a running period. The check must show that the write changes nothing until the wrap from unit 199. The bench does this by stepping the scan tick unit by unit, comparing every unit of every period, and changing the duty input at unit 50 of one period. The expected value of the next period is the new duty, clamped where it is above 198. The clamped case is the only way to observe the dead units at 99 and 199 while the neighbouring units are driven.

// File: rtl/fil_pkg.sv
package fil_pkg;

  // Bridge output pair: bit 0 drives the first phase, bit 1 the second.
  typedef struct packed {
    logic b;
    logic a;
  } phase_pair_t;

  // Bridge drive mode selected by the enable input.
  typedef enum logic {
    MODE_GPO = 1'b0,
    MODE_PWM = 1'b1
  } out_mode_e;

endpackage

// File: rtl/fil_timebase.sv
module fil_timebase #(
  parameter int PERIOD_UNITS = 200,
  parameter int CNT_W        = $clog2(PERIOD_UNITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  output logic [CNT_W-1:0] unit_cnt,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] LAST_UNIT = CNT_W'(PERIOD_UNITS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  // Counter only moves on a scan tick or when drive is switched off.
  assign cnt_ce = !en || tick;
  assign wrap   = en && tick && (cnt_q == LAST_UNIT);

  always_comb begin
    cnt_d = cnt_q;
    if (!en) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = (cnt_q == LAST_UNIT) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign unit_cnt = cnt_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_UNIT);

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> (cnt_q == $past(cnt_q)));

  // R11
  cnt_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));

endmodule

// File: rtl/fil_duty_shadow.sv
module fil_duty_shadow #(
  parameter int DUTY_W   = 8,
  parameter int DUTY_MAX = 198
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wrap,
  input  logic [DUTY_W-1:0] duty_in,
  output logic [DUTY_W-1:0] on_first,
  output logic [DUTY_W-1:0] on_second
);

  localparam logic [DUTY_W-1:0] DUTY_MAX_C = DUTY_W'(DUTY_MAX);

  logic [DUTY_W-1:0] shadow_q, shadow_d;
  logic [DUTY_W-1:0] duty_clamped;
  logic              shadow_ce;
  logic [DUTY_W:0]   round_up;

  assign duty_clamped = (duty_in > DUTY_MAX_C) ? DUTY_MAX_C : duty_in;

  // Load while idle (so enabling starts fresh) or at the period boundary.
  assign shadow_ce = !en || wrap;

  always_comb begin
    shadow_d = shadow_q;
    if (shadow_ce) begin
      shadow_d = duty_clamped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (shadow_ce) begin
      shadow_q <= shadow_d;
    end
  end

  // Odd duty: the extra unit goes to the first half.
  assign round_up  = {1'b0, shadow_q} + 1'b1;
  assign on_first  = round_up[DUTY_W:1];
  assign on_second = {1'b0, shadow_q[DUTY_W-1:1]};

  // R5
  shadow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_q <= DUTY_MAX_C);

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> $stable(shadow_q));

endmodule

// File: rtl/fil_phase_gen.sv
module fil_phase_gen
  import fil_pkg::*;
#(
  parameter int PERIOD_UNITS = 200,
  parameter int CNT_W        = $clog2(PERIOD_UNITS),
  parameter int DUTY_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CNT_W-1:0]  unit_cnt,
  input  logic [DUTY_W-1:0] on_first,
  input  logic [DUTY_W-1:0] on_second,
  input  logic [1:0]        gpo,
  output phase_pair_t       phases
);

  localparam int CW   = (CNT_W > DUTY_W) ? CNT_W : DUTY_W;
  localparam int HALF = PERIOD_UNITS / 2;
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);

  logic [1:0]  pwm_raw;
  logic        upper_half;
  phase_pair_t out_q, out_d;
  out_mode_e   mode_q, mode_d;

  assign upper_half = (unit_cnt >= HALF_C);

  // One comparator per phase; phase g owns half-period g.
  for (genvar g = 0; g < 2; g++) begin : g_phase
    logic [CNT_W-1:0]  offset;
    logic [DUTY_W-1:0] on_units;
    logic              in_half;

    assign in_half  = (g == 0) ? !upper_half : upper_half;
    assign offset   = (g == 0) ? unit_cnt : unit_cnt - HALF_C;
    assign on_units = (g == 0) ? on_first : on_second;
    assign pwm_raw[g] = in_half && (CW'(offset) < CW'(on_units));
  end

  always_comb begin
    mode_d = en ? MODE_PWM : MODE_GPO;
    if (en) begin
      out_d.a = pwm_raw[0];
      out_d.b = pwm_raw[1];
    end else begin
      out_d.a = gpo[0];
      out_d.b = gpo[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      mode_q <= MODE_GPO;
    end else begin
      out_q  <= out_d;
      mode_q <= mode_d;
    end
  end

  assign phases = out_q;

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PWM) |-> !(out_q.a && out_q.b));

  // R6
  dead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_PWM) && ($past(mode_q) == MODE_PWM) && $past(out_q.a))
      |-> !out_q.b);

  // R3
  half_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && upper_half) |=> !out_q.a);

endmodule

// File: rtl/fil_bridge_pwm.sv
module fil_bridge_pwm
  import fil_pkg::*;
#(
  parameter int PERIOD_UNITS = 200,
  parameter int DEAD_UNITS   = 1,
  parameter int DUTY_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_tick,
  input  logic              fil_en,
  input  logic [DUTY_W-1:0] duty,
  input  logic [1:0]        gpo,
  output logic              phase_a,
  output logic              phase_b
);

  localparam int CNT_W    = $clog2(PERIOD_UNITS);
  localparam int DUTY_MAX = PERIOD_UNITS - 2 * DEAD_UNITS;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [CNT_W-1:0]  unit_cnt;
  logic              wrap;
  logic [DUTY_W-1:0] on_first, on_second;
  phase_pair_t       phases;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  fil_timebase #(
    .PERIOD_UNITS (PERIOD_UNITS),
    .CNT_W        (CNT_W)
  ) u_timebase (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (fil_en),
    .tick     (scan_tick),
    .unit_cnt (unit_cnt),
    .wrap     (wrap)
  );

  fil_duty_shadow #(
    .DUTY_W   (DUTY_W),
    .DUTY_MAX (DUTY_MAX)
  ) u_shadow (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (fil_en),
    .wrap      (wrap),
    .duty_in   (duty),
    .on_first  (on_first),
    .on_second (on_second)
  );

  fil_phase_gen #(
    .PERIOD_UNITS (PERIOD_UNITS),
    .CNT_W        (CNT_W),
    .DUTY_W       (DUTY_W)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (fil_en),
    .unit_cnt  (unit_cnt),
    .on_first  (on_first),
    .on_second (on_second),
    .gpo       (gpo),
    .phases    (phases)
  );

  assign phase_a = phases.a;
  assign phase_b = phases.b;

  // R9
  gpo_follow_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !fil_en |=> ({phase_b, phase_a} == $past(gpo)));

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_low_chk: assert (!phase_a && !phase_b || $isunknown(rst_n));
    end
  end

endmodule

// File: tb/tb_fil_bridge_pwm.sv
module tb_fil_bridge_pwm;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scan_tick;
  logic       fil_en;
  logic [7:0] duty;
  logic [1:0] gpo;
  logic       phase_a, phase_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fil_bridge_pwm dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_tick (scan_tick),
    .fil_en    (fil_en),
    .duty      (duty),
    .gpo       (gpo),
    .phase_a   (phase_a),
    .phase_b   (phase_b)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step_tick();
    @(negedge clk) scan_tick = 1'b1;
    @(negedge clk) scan_tick = 1'b0;
    @(negedge clk);
  endtask

  function automatic bit exp_a(int k, int d);
    return (k < 100) && (k < (d + 1) / 2);
  endfunction

  function automatic bit exp_b(int k, int d);
    return (k >= 100) && ((k - 100) < d / 2);
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; scan_tick = 1'b0; fil_en = 1'b0; duty = 8'd50; gpo = 2'b11;
    repeat (3) @(negedge clk);
    check({phase_b, phase_a} == 2'b00, "R1", {phase_b, phase_a}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_gpo();
    fil_en = 1'b0;
    for (int v = 0; v < 4; v++) begin
      gpo = 2'(v);
      @(negedge clk); @(negedge clk);
      check({phase_b, phase_a} == 2'(v), "R9", {phase_b, phase_a}, v);
    end
  endtask

  task automatic t_enable(input int d);
    duty = 8'(d);
    @(negedge clk);
    fil_en = 1'b1;
    @(negedge clk); @(negedge clk);
    check(phase_a == exp_a(0, d) && !phase_b, "R11", {phase_b, phase_a}, {1'b0, exp_a(0, d)});
  endtask

  // Walk one full period, comparing each unit; optionally rewrite duty at unit 50.
  task automatic t_period(input int d_eff, input bit do_change, input int new_duty);
    int high_units = 0;
    for (int k = 0; k < 200; k++) begin
      string lbl;
      bit ea, eb;
      ea = exp_a(k, d_eff);
      eb = exp_b(k, d_eff);
      if (d_eff == 0) lbl = "R10";
      else if (d_eff == 198) lbl = "R5";
      else if (k < 100) lbl = "R2";
      else lbl = "R3";
      check(phase_a == ea && phase_b == eb, lbl, {phase_b, phase_a}, {eb, ea});
      if (phase_a && phase_b) check(1'b0, "R6", 3, 0);
      if (k == 99 || k == 199) check(!phase_a && !phase_b, "R6", {phase_b, phase_a}, 0);
      if (phase_a || phase_b) high_units++;
      if (k == 50 && do_change) begin
        @(negedge clk) duty = 8'(new_duty);
        @(negedge clk);
        check(phase_a == ea && phase_b == eb, "R7", {phase_b, phase_a}, {eb, ea});
      end
      if (k == 130) begin
        for (int w = 0; w < 20; w++) begin
          @(negedge clk);
          if (phase_a != ea || phase_b != eb) check(1'b0, "R8", {phase_b, phase_a}, {eb, ea});
        end
        check(phase_a == ea && phase_b == eb, "R8", {phase_b, phase_a}, {eb, ea});
      end
      step_tick();
    end
    check(high_units == d_eff, "R4", high_units, d_eff);
  endtask

  task automatic t_restart();
    fil_en = 1'b0;
    gpo = 2'b10;
    @(negedge clk); @(negedge clk);
    check({phase_b, phase_a} == 2'b10, "R9", {phase_b, phase_a}, 2);
    t_enable(10);
    for (int k = 0; k < 5; k++) step_tick();
    check(!phase_a && !phase_b, "R11", {phase_b, phase_a}, 0);
  endtask

  initial begin
    t_reset();
    t_gpo();
    t_enable(37);
    t_period(37, 1'b1, 120);
    t_period(120, 1'b1, 250);
    t_period(198, 1'b1, 0);
    t_period(0, 1'b0, 0);
    t_restart();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule